// File: doc/BRIEF.md
# LCD Frame Rate Divider

This block sets the frame timing of an LCD waveform sequencer. It runs entirely on an already-prescaled low-frequency LCD clock. It first divides that clock by (1 + divide setting). It then counts the divided ticks through a mux-dependent number of phase steps, and that count of steps makes up one frame. The frame rate is therefore the LCD clock / ((1 + divide) × steps).

The downstream sequencer uses three outputs. `step_o` is high for one cycle at each phase step. `phase_o` gives the current common-phase index. `frame_start_o` is high for one cycle at the first step of every frame. The divide and mux settings are captured when the block is enabled and stay fixed until it is disabled again. This means software changes can never stretch or shorten a frame partway through.

Top module: `lcd_frame_div`

## Requirements
- R1: While rst_ni is low, step_o and frame_start_o are 0 and phase_o is 0.
- R2: At any rising clock edge where en_i is sampled low, all internal counting stops. For the following cycle, step_o and frame_start_o are 0 and phase_o is 0.
- R3: The first rising edge at which en_i is sampled high is the enable edge. step_o is first high during the cycle that begins (div_i) edges after the enable edge. After that, step_o is high for one cycle out of every (1 + div_i) cycles. div_i = 0 gives a step every cycle and div_i = 7 gives a step every 8 cycles.
- R4: phase_o starts at 0 and moves up by one on the edge that ends a step_o cycle. After reaching N−1 it wraps to 0. N depends on mux_i: code 0 gives 2, 1 gives 4, 2 gives 6, 3 gives 8, 4 gives 12, and 5 gives 16.
- R5: mux_i codes 6 and 7 behave exactly like code 0, with N = 2.
- R6: frame_start_o is high exactly in those step_o cycles where phase_o is 0. This covers the first step after enable and every step after a wrap. Successive frame_start_o pulses are therefore (1 + div) × N cycles apart.
- R7: div_i and mux_i are captured only on the enable edge. Changes to them while en_i stays high have no effect until en_i has been low for at least one edge and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-frequency LCD clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Frame timing enable |
| div_i | input | 3 | Frame predivide setting (divide by 1 + value) |
| mux_i | input | 3 | Multiplex mode select |
| step_o | output | 1 | One-cycle phase-step strobe |
| phase_o | output | 4 | Current common-phase index |
| frame_start_o | output | 1 | One-cycle pulse on the first step of each frame |

## Verification
All three outputs come from registers that are updated on the rising edge. Their values therefore belong to the cycle after the edge that caused them. An enable or disable sampled at edge k shows on the outputs right after edge k. The first step comes div edges later. A phase advance follows the edge that closes a step cycle. The bench drives inputs 1 ns after each rising edge. It samples outputs on the falling edge and compares them there against a behavioural model that was advanced at the same rising edge. Frame periods are measured in rising edges between two frame_start_o samples.

// File: rtl/lcd_fr_pkg.sv
package lcd_fr_pkg;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned PH_W   = 4;

  typedef enum logic [MODE_W-1:0] {
    MUX_STATIC = 3'd0,
    MUX_DUPLEX = 3'd1,
    MUX_TRIPLE = 3'd2,
    MUX_QUAD   = 3'd3,
    MUX_SEXT   = 3'd4,
    MUX_OCT    = 3'd5
  } mux_mode_e;

  // Last phase index (steps per frame minus one) for a mode code.
  function automatic logic [PH_W-1:0] last_phase(input logic [MODE_W-1:0] m);
    case (m)
      MUX_DUPLEX: last_phase = PH_W'(3);
      MUX_TRIPLE: last_phase = PH_W'(5);
      MUX_QUAD:   last_phase = PH_W'(7);
      MUX_SEXT:   last_phase = PH_W'(11);
      MUX_OCT:    last_phase = PH_W'(15);
      default:    last_phase = PH_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/lcd_fr_cfg.sv
module lcd_fr_cfg
  import lcd_fr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [MODE_W-1:0] mux_i,
  output logic              run_o,
  output logic              start_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [PH_W-1:0]   last_o
);
  logic              run_q;
  logic [DIV_W-1:0]  div_q;
  logic [PH_W-1:0]   last_q;

  assign start_o = en_i && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      last_q <= PH_W'(1);
    end else begin
      run_q <= en_i;
      if (start_o) begin
        div_q  <= div_i;
        last_q <= last_phase(mux_i);
      end
    end
  end

  assign run_o  = run_q;
  assign div_o  = div_q;
  assign last_o = last_q;
endmodule

// File: rtl/lcd_fr_prediv.sv
module lcd_fr_prediv
  import lcd_fr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_fr_phase.sv
module lcd_fr_phase
  import lcd_fr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic [PH_W-1:0] last_i,
  output logic [PH_W-1:0] phase_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= '0;
    else if (clr_i)           ph_q <= '0;
    else if (tick_i) begin
      if (ph_q >= last_i)     ph_q <= '0;
      else                    ph_q <= ph_q + 1'b1;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/lcd_frame_div.sv
module lcd_frame_div
  import lcd_fr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [MODE_W-1:0] mux_i,
  output logic              step_o,
  output logic [PH_W-1:0]   phase_o,
  output logic              frame_start_o
);
  logic             run_q;
  logic             start;
  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  last_q;
  logic             clr;
  logic             tick;
  logic [PH_W-1:0]  phase;

  assign clr = !en_i || start;

  lcd_fr_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .div_i   (div_i),
    .mux_i   (mux_i),
    .run_o   (run_q),
    .start_o (start),
    .div_o   (div_q),
    .last_o  (last_q)
  );

  lcd_fr_prediv u_prediv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .run_i  (run_q),
    .div_i  (div_q),
    .tick_o (tick)
  );

  lcd_fr_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (tick),
    .last_i  (last_q),
    .phase_o (phase)
  );

  assign step_o        = tick;
  assign phase_o       = phase;
  assign frame_start_o = tick && (phase == '0);
endmodule

// File: rtl/lcd_frame_div_chk.sv
module lcd_frame_div_chk
  import lcd_fr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             step_o,
  input logic [PH_W-1:0]  phase_o,
  input logic             frame_start_o,
  input logic             run_q,
  input logic [DIV_W-1:0] div_q,
  input logic [PH_W-1:0]  last_q
);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!step_o && !frame_start_o && phase_o == '0));

  p_enable_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run_q) |=> (phase_o == '0 && step_o == (div_q == '0)));

  p_hold_between_steps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_o) |=> $stable(phase_o));

  p_phase_moves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_q && step_o) |=> (phase_o != $past(phase_o)));

  p_phase_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= last_q);

  p_frame_on_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (step_o && phase_o == '0));

  p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_q) |=> ($stable(div_q) && $stable(last_q)));
endmodule

bind lcd_frame_div lcd_frame_div_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .step_o        (step_o),
  .phase_o       (phase_o),
  .frame_start_o (frame_start_o),
  .run_q         (run_q),
  .div_q         (div_q),
  .last_q        (last_q)
);

// File: tb/lcd_frame_div_tb.sv
module lcd_frame_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] div = 3'd0;
  logic [2:0] mux = 3'd0;
  logic       step;
  logic [3:0] phase;
  logic       fstart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_frame_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div), .mux_i(mux),
    .step_o(step), .phase_o(phase), .frame_start_o(fstart)
  );

  function automatic int steps_of(input int m);
    case (m)
      1: return 4;
      2: return 6;
      3: return 8;
      4: return 12;
      5: return 16;
      default: return 2;
    endcase
  endfunction

  // Behavioural reference model
  int  m_run = 0, m_pre = 0, m_ph = 0, m_div = 0, m_n = 2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_pre = 0; m_ph = 0;
    end else if (!en) begin
      m_run = 0; m_pre = 0; m_ph = 0;
    end else if (m_run == 0) begin
      m_run = 1; m_pre = 0; m_ph = 0; m_div = int'(div); m_n = steps_of(int'(mux));
    end else if (m_pre == m_div) begin
      m_pre = 0;
      m_ph = (m_ph == m_n - 1) ? 0 : m_ph + 1;
    end else begin
      m_pre = m_pre + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit e_step = (m_run != 0) && (m_pre == m_div);
      automatic bit e_fs   = e_step && (m_ph == 0);
      checks++;
      if (step !== e_step) begin
        errors++;
        $display("FAIL %s step_o: got %0b exp %0b", (m_run != 0) ? "R3" : "R2", step, e_step);
      end
      checks++;
      if (phase !== 4'(m_ph)) begin
        errors++;
        $display("FAIL %s phase_o: got %0d exp %0d", (m_run != 0) ? "R4" : "R2", phase, m_ph);
      end
      checks++;
      if (fstart !== e_fs) begin
        errors++;
        $display("FAIL %s frame_start_o: got %0b exp %0b", (m_run != 0) ? "R6" : "R2", fstart, e_fs);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  // Period in cycles between two consecutive frame starts
  task automatic frame_period(output int p);
    int guard = 0;
    while (!fstart && guard < 1000) begin cyc(1); guard++; end
    p = 0;
    cyc(1);
    p = 1;
    while (!fstart && guard < 2000) begin cyc(1); p++; guard++; end
  endtask

  // Run one configuration; optionally disturb the inputs while enabled (R7)
  task automatic run_cfg(input int d, input int m, input bit disturb, input string tag);
    int p;
    int first;
    en = 1'b0;
    cyc(2);
    div = 3'(d); mux = 3'(m);
    en = 1'b1;
    cyc(1);
    first = 0;
    while (!step && first < 20) begin cyc(1); first++; end
    chk({tag, " first step delay"}, first, d);
    if (disturb) begin
      div = 3'(7 - d); mux = 3'((m + 3) % 8);
    end
    frame_period(p);
    chk({tag, " frame period"}, p, (1 + d) * steps_of(m));
    frame_period(p);
    chk({tag, " frame period repeat"}, p, (1 + d) * steps_of(m));
  endtask

  initial begin
    #7;
    chk("R1 step_o in reset", int'(step), 0);
    chk("R1 phase_o in reset", int'(phase), 0);
    chk("R1 frame_start_o in reset", int'(fstart), 0);
    #20;
    rst_n = 1'b1;
    cyc(2);
    // Enable low: nothing moves
    div = 3'd0; mux = 3'd5;
    cyc(5);
    chk("R2 idle step_o", int'(step), 0);
    chk("R2 idle phase_o", int'(phase), 0);

    for (int m = 0; m < 6; m++) run_cfg(m % 2 == 0 ? 0 : 3, m, 1'b0, "R4");
    run_cfg(0, 0, 1'b0, "R3 div0");
    run_cfg(7, 5, 1'b0, "R3 div7");
    run_cfg(2, 6, 1'b0, "R5 code6");
    run_cfg(5, 7, 1'b0, "R5 code7");
    run_cfg(1, 2, 1'b1, "R7 frozen");
    run_cfg(4, 4, 1'b1, "R7 frozen");
    run_cfg(0, 1, 1'b0, "R6");

    en = 1'b0;
    cyc(1);
    chk("R2 disable step_o", int'(step), 0);
    chk("R2 disable frame_start_o", int'(fstart), 0);
    chk("R2 disable phase_o", int'(phase), 0);
    cyc(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule